// File: doc/BRIEF.md
# Packed Masked Integer-to-Float Converter

This block turns a packed vector of signed 32-bit integers into IEEE-754 single-precision values, one result per 32-bit lane, for the vector execution pipe of a processor. A length select picks 4, 8 or 16 active lanes. Lane j always occupies bits 32*j+31 down to 32*j. An encoding-form select chooses among three behaviours. The legacy form is fixed at 128 bits, has no mask and leaves the bits above its length untouched. The plain vector form clears the bits above the chosen length. The masked vector form adds a per-lane write mask with merge or zero behaviour, broadcast of one 32-bit element, and a static rounding override.

A controller state machine has three states. `ST_IDLE` means nothing is being presented. `ST_WRITE` presents a converted result. `ST_FAULT` presents a suppressed write caused by an invalid encoding. Every cycle the next state follows the input strobe. Without `in_valid` the machine goes to `ST_IDLE`. With `in_valid` and a legal encoding it goes to `ST_WRITE`. With `in_valid` and an illegal encoding it goes to `ST_FAULT`. These transitions apply from any state. The result, the inexact flag and the fault flag come from registers and appear one cycle after the strobe.

Top module: `i2f_packed_top`

## Requirements
- R1: `len_sel` 2'b00 gives 4 active lanes, 2'b01 gives 8, and 2'b10 or 2'b11 gives 16. The legacy form (`form_sel` 2'b00) always uses 4 lanes. Lane j is bits 32*j+31:32*j of every vector.
- R2: Each converted lane holds the single-precision value of its signed integer. Zero gives 32'h00000000, -2^31 gives 32'hCF000000, and rounding may carry into the exponent (32'h7FFFFFFF to nearest gives 32'h4F000000).
- R3: The rounding code is 2'b00 nearest-even, 2'b01 toward minus infinity, 2'b10 toward plus infinity, and 2'b11 toward zero.
- R4: An active lane is converted when masking is off or its `lane_mask` bit is 1. Masking applies only in the masked form (`form_sel[1]`=1) with `mask_en`=1.
- R5: An active masked-off lane keeps `old_dst` when `zero_mode`=0 and becomes zero when `zero_mode`=1.
- R6: In the masked form with `src_mem`=1 and `bcst_rnd`=1, every converted lane uses `src_vec[31:0]`. With a register source, no broadcast takes place.
- R7: `emb_rc` is used only in the masked form with 16 lanes, `src_mem`=0 and `bcst_rnd`=1. In every other case `glob_rc` applies.
- R8: Bits above the active length are zero in the plain and masked forms. In the legacy form they are copied from `old_dst`.
- R9: `inexact` is the OR of the rounding-loss conditions of the converted lanes only.
- R10: In the plain or masked form, `spec_field` other than 4'hF sets `bad_enc`, keeps the result at `old_dst` and clears `inexact`. The legacy form never faults.
- R11: `out_valid` is high exactly one cycle after an `in_valid` cycle. Without `in_valid`, the result and flags hold their values.
- R12: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation strobe |
| src_vec | input | 512 | Packed signed integer source |
| old_dst | input | 512 | Previous destination contents |
| lane_mask | input | 16 | Per-lane write mask |
| form_sel | input | 2 | 00 legacy, 01 plain, 1x masked form |
| len_sel | input | 2 | Vector length select |
| mask_en | input | 1 | Masking enabled (masked form only) |
| zero_mode | input | 1 | 1 zeroes masked-off lanes, 0 merges |
| src_mem | input | 1 | Source is a memory operand |
| bcst_rnd | input | 1 | Broadcast / rounding-override bit |
| emb_rc | input | 2 | Embedded rounding code |
| glob_rc | input | 2 | Global control rounding code |
| spec_field | input | 4 | Unused register specifier, must be 4'hF |
| out_valid | output | 1 | Result valid |
| res_vec | output | 512 | Result vector |
| inexact | output | 1 | Precision flag |
| bad_enc | output | 1 | Invalid-encoding flag |

## Verification
The bench builds the block with its default parameters: 16 lanes of 32 bits, the full 512-bit width. At that size every length, form and mask behaviour can be reached. All four rounding codes are swept over hand-picked corner integers and over a stream of pseudo-random values whose magnitudes are spread by shifts. Every one of the 16 low mask patterns is tried in both merge and zero mode. Every form is tried at every length, which covers every path that selects the rounding source and the upper-bit treatment.

// File: rtl/i2f_pkg.sv
package i2f_pkg;
    localparam int LANE_W = 32;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'b00,
        RM_DOWN    = 2'b01,
        RM_UP      = 2'b10,
        RM_TOZERO  = 2'b11
    } rmode_e;

    typedef enum logic [1:0] {
        LS_CONVERT = 2'b00,
        LS_KEEP    = 2'b01,
        LS_CLEAR   = 2'b10
    } lane_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_WRITE = 2'b01,
        ST_FAULT = 2'b10
    } ctl_state_e;
endpackage

// File: rtl/i2f_lane.sv
module i2f_lane
    import i2f_pkg::*;
(
    input  logic [LANE_W-1:0] int_in,
    input  logic [1:0]        rmode,
    output logic [31:0]       fp_out,
    output logic              inexact
);
    localparam int MANT_W = 23;
    localparam int BIAS   = 127;

    logic              sgn;
    logic [31:0]       mag;
    logic [4:0]        msb;
    logic [4:0]        shamt;
    logic [23:0]       kept;
    logic [31:0]       rem;
    logic [31:0]       half;
    logic              grd;
    logic              stk;
    logic              bump;
    logic [24:0]       summed;
    logic [7:0]        expo;

    always_comb begin
        sgn = int_in[31];
        mag = sgn ? (~int_in + 32'd1) : int_in;
        msb = 5'd0;
        for (int b = 0; b < 32; b++) begin
            if (mag[b]) msb = 5'(b);
        end
        shamt = 5'd0;
        rem   = 32'd0;
        half  = 32'd0;
        if (msb <= 5'(MANT_W)) begin
            kept = 24'(mag << (5'(MANT_W) - msb));
            grd  = 1'b0;
            stk  = 1'b0;
        end else begin
            shamt = msb - 5'(MANT_W);
            kept  = 24'(mag >> shamt);
            rem   = mag & ((32'd1 << shamt) - 32'd1);
            half  = 32'd1 << (shamt - 5'd1);
            grd   = |(rem & half);
            stk   = |(rem & (half - 32'd1));
        end
        inexact = grd | stk;
        unique case (rmode_e'(rmode))
            RM_NEAREST: bump = grd & (stk | kept[0]);
            RM_DOWN:    bump = inexact & sgn;
            RM_UP:      bump = inexact & ~sgn;
            RM_TOZERO:  bump = 1'b0;
            default:    bump = 1'b0;
        endcase
        summed = {1'b0, kept} + {24'd0, bump};
        expo   = 8'(BIAS) + {3'd0, msb} + {7'd0, summed[24]};
        fp_out = {sgn, expo, summed[24] ? 23'd0 : summed[MANT_W-1:0]};
        if (mag == 32'd0) begin
            fp_out  = 32'd0;
            inexact = 1'b0;
        end
    end
endmodule

// File: rtl/i2f_decode.sv
module i2f_decode
    import i2f_pkg::*;
#(
    parameter int LANES = 16
) (
    input  logic [1:0]       form_sel,
    input  logic [1:0]       len_sel,
    input  logic             mask_en,
    input  logic [LANES-1:0] lane_mask,
    input  logic             zero_mode,
    input  logic             src_mem,
    input  logic             bcst_rnd,
    input  logic [1:0]       emb_rc,
    input  logic [1:0]       glob_rc,
    input  logic [3:0]       spec_field,
    output lane_sel_e        sel [LANES],
    output logic             bcst_en,
    output logic [1:0]       rmode,
    output logic             bad
);
    localparam int CNT_W = $clog2(LANES + 1) + 1;

    logic             is_legacy;
    logic             is_masked_form;
    logic [CNT_W-1:0] act_cnt;
    logic             use_emb;

    always_comb begin
        is_legacy      = (form_sel == 2'b00);
        is_masked_form = form_sel[1];
        if (is_legacy || len_sel == 2'b00) act_cnt = CNT_W'(4);
        else if (len_sel == 2'b01)         act_cnt = CNT_W'(8);
        else                               act_cnt = CNT_W'(16);
        use_emb = is_masked_form & len_sel[1] & ~src_mem & bcst_rnd;
        rmode   = use_emb ? emb_rc : glob_rc;
        bcst_en = is_masked_form & src_mem & bcst_rnd;
        bad     = ~is_legacy & (spec_field != 4'hF);
    end

    for (genvar j = 0; j < LANES; j++) begin : g_sel
        always_comb begin
            if (CNT_W'(j) >= act_cnt)
                sel[j] = is_legacy ? LS_KEEP : LS_CLEAR;
            else if (is_masked_form && mask_en && !lane_mask[j])
                sel[j] = zero_mode ? LS_CLEAR : LS_KEEP;
            else
                sel[j] = LS_CONVERT;
        end
    end
endmodule

// File: rtl/i2f_packed_top.sv
module i2f_packed_top
    import i2f_pkg::*;
#(
    parameter int LANES = 16,
    localparam int VEC_W = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [VEC_W-1:0] src_vec,
    input  logic [VEC_W-1:0] old_dst,
    input  logic [LANES-1:0] lane_mask,
    input  logic [1:0]       form_sel,
    input  logic [1:0]       len_sel,
    input  logic             mask_en,
    input  logic             zero_mode,
    input  logic             src_mem,
    input  logic             bcst_rnd,
    input  logic [1:0]       emb_rc,
    input  logic [1:0]       glob_rc,
    input  logic [3:0]       spec_field,
    output logic             out_valid,
    output logic [VEC_W-1:0] res_vec,
    output logic             inexact,
    output logic             bad_enc
);
    lane_sel_e        sel [LANES];
    logic             bcst_en;
    logic [1:0]       rmode;
    logic             dec_bad;
    logic [VEC_W-1:0] res_comb;
    logic [LANES-1:0] lane_inx;
    logic [LANES-1:0] lane_conv;
    ctl_state_e       state_q;
    ctl_state_e       state_d;
    logic [VEC_W-1:0] res_q;
    logic             inx_q;

    i2f_decode #(.LANES(LANES)) u_decode (
        .form_sel   (form_sel),
        .len_sel    (len_sel),
        .mask_en    (mask_en),
        .lane_mask  (lane_mask),
        .zero_mode  (zero_mode),
        .src_mem    (src_mem),
        .bcst_rnd   (bcst_rnd),
        .emb_rc     (emb_rc),
        .glob_rc    (glob_rc),
        .spec_field (spec_field),
        .sel        (sel),
        .bcst_en    (bcst_en),
        .rmode      (rmode),
        .bad        (dec_bad)
    );

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [LANE_W-1:0] opnd;
        logic [31:0]       fp;
        logic              ix;

        assign opnd = bcst_en ? src_vec[LANE_W-1:0] : src_vec[j*LANE_W +: LANE_W];

        i2f_lane u_lane (
            .int_in  (opnd),
            .rmode   (rmode),
            .fp_out  (fp),
            .inexact (ix)
        );

        always_comb begin
            lane_conv[j] = (sel[j] == LS_CONVERT);
            lane_inx[j]  = ix & lane_conv[j];
            unique case (sel[j])
                LS_CONVERT: res_comb[j*LANE_W +: LANE_W] = fp;
                LS_KEEP:    res_comb[j*LANE_W +: LANE_W] = old_dst[j*LANE_W +: LANE_W];
                default:    res_comb[j*LANE_W +: LANE_W] = '0;
            endcase
        end
    end

    // next-state logic
    always_comb begin
        unique case (state_q)
            ST_IDLE, ST_WRITE, ST_FAULT: begin
                if (!in_valid)    state_d = ST_IDLE;
                else if (dec_bad) state_d = ST_FAULT;
                else              state_d = ST_WRITE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // result capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
            inx_q <= 1'b0;
        end else if (in_valid) begin
            res_q <= dec_bad ? old_dst : res_comb;
            inx_q <= ~dec_bad & (|lane_inx);
        end
    end

    // outputs
    always_comb begin
        res_vec = res_q;
        inexact = inx_q;
        unique case (state_q)
            ST_WRITE: begin out_valid = 1'b1; bad_enc = 1'b0; end
            ST_FAULT: begin out_valid = 1'b1; bad_enc = 1'b1; end
            default:  begin out_valid = 1'b0; bad_enc = 1'b0; end
        endcase
    end

    assert_strobe_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(res_vec) && $stable(inexact)));
    assert_fault_keeps_dst_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dec_bad) |=> (bad_enc && !inexact && res_vec == $past(old_dst)));
    assert_no_conv_no_inexact_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane_conv == '0) |=> !inexact);
endmodule

// File: tb/i2f_packed_top_bench.sv
module i2f_packed_top_bench;
    localparam int CLK_P = 10;
    localparam int NL    = 16;
    localparam int VW    = NL * 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [VW-1:0] src_vec = '0;
    logic [VW-1:0] old_dst = '0;
    logic [NL-1:0] lane_mask = '0;
    logic [1:0]    form_sel = 2'b10;
    logic [1:0]    len_sel = 2'b10;
    logic          mask_en = 1'b0;
    logic          zero_mode = 1'b0;
    logic          src_mem = 1'b0;
    logic          bcst_rnd = 1'b0;
    logic [1:0]    emb_rc = 2'b00;
    logic [1:0]    glob_rc = 2'b00;
    logic [3:0]    spec_field = 4'hF;
    logic          out_valid;
    logic [VW-1:0] res_vec;
    logic          inexact;
    logic          bad_enc;

    int checks = 0;
    int failures = 0;
    logic [31:0] rng = 32'h1234_5678;

    always #(CLK_P/2) clk = ~clk;

    i2f_packed_top u_i2f_packed_top (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_vec(src_vec),
        .old_dst(old_dst), .lane_mask(lane_mask), .form_sel(form_sel),
        .len_sel(len_sel), .mask_en(mask_en), .zero_mode(zero_mode),
        .src_mem(src_mem), .bcst_rnd(bcst_rnd), .emb_rc(emb_rc),
        .glob_rc(glob_rc), .spec_field(spec_field), .out_valid(out_valid),
        .res_vec(res_vec), .inexact(inexact), .bad_enc(bad_enc)
    );

    function automatic logic [31:0] next_rng(logic [31:0] x);
        logic [31:0] y = x;
        y = y ^ (y << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    // reference: normalise to bit 31 then round the low 8 bits away
    function automatic logic [31:0] ref_conv(logic [31:0] v, logic [1:0] rm, output logic ix);
        logic        neg;
        logic [31:0] m;
        int          e;
        logic [24:0] k;
        logic [7:0]  r;
        logic        up;
        ix = 1'b0;
        if (v == 32'd0) return 32'd0;
        neg = v[31];
        m = neg ? (32'd0 - v) : v;
        e = 31;
        while (!m[31]) begin
            m = m << 1;
            e = e - 1;
        end
        k = {1'b0, m[31:8]};
        r = m[7:0];
        ix = (r != 8'd0);
        case (rm)
            2'b00:   up = (r > 8'd128) || (r == 8'd128 && k[0]);
            2'b01:   up = ix && neg;
            2'b10:   up = ix && !neg;
            default: up = 1'b0;
        endcase
        k = k + {24'd0, up};
        if (k[24]) begin
            k = 25'h0800000;
            e = e + 1;
        end
        return {neg, 8'(e + 127), k[22:0]};
    endfunction

    task automatic model(output logic [VW-1:0] ev, output logic eix, output logic ebad);
        int n;
        logic [1:0] rm;
        logic [31:0] v;
        logic lx;
        ev = '0;
        eix = 1'b0;
        ebad = (form_sel != 2'b00) && (spec_field != 4'hF);
        if (ebad) begin
            ev = old_dst;
            return;
        end
        if (form_sel == 2'b00 || len_sel == 2'b00) n = 4;
        else if (len_sel == 2'b01) n = 8;
        else n = 16;
        rm = (form_sel[1] && len_sel[1] && !src_mem && bcst_rnd) ? emb_rc : glob_rc;
        for (int j = 0; j < NL; j++) begin
            if (j >= n)
                ev[j*32 +: 32] = (form_sel == 2'b00) ? old_dst[j*32 +: 32] : 32'd0;
            else if (form_sel[1] && mask_en && !lane_mask[j])
                ev[j*32 +: 32] = zero_mode ? 32'd0 : old_dst[j*32 +: 32];
            else begin
                v = (form_sel[1] && src_mem && bcst_rnd) ? src_vec[31:0] : src_vec[j*32 +: 32];
                ev[j*32 +: 32] = ref_conv(v, rm, lx);
                eix = eix | lx;
            end
        end
    endtask

    task automatic chk(string req, logic [VW-1:0] act, logic [VW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic issue(string req);
        logic [VW-1:0] ev;
        logic eix;
        logic ebad;
        @(negedge clk);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        model(ev, eix, ebad);
        chk({req, " result"}, res_vec, ev);
        chk({req, " inexact R9"}, VW'(inexact), VW'(eix));
        chk({req, " bad R10"}, VW'(bad_enc), VW'(ebad));
        chk({req, " valid R11"}, VW'(out_valid), VW'(1));
    endtask

    function automatic logic [31:0] corner(int j);
        case (j)
            0: return 32'h0000_0000;   1: return 32'h0000_0001;
            2: return 32'hFFFF_FFFF;   3: return 32'h8000_0000;
            4: return 32'h7FFF_FFFF;   5: return 32'h00FF_FFFF;
            6: return 32'h0100_0000;   7: return 32'h0100_0001;
            8: return 32'h0100_0003;   9: return 32'hFEFF_FFFF;
            10: return 32'h0080_0001;  11: return 32'h0200_0002;
            12: return 32'h7FFF_FFC0;  13: return 32'hFFFF_FF81;
            14: return 32'h4000_0040;  default: return 32'hC000_0041;
        endcase
    endfunction

    task automatic fill_random();
        for (int j = 0; j < NL; j++) begin
            rng = next_rng(rng);
            src_vec[j*32 +: 32] = 32'($signed(rng) >>> rng[4:0]);
            rng = next_rng(rng);
            old_dst[j*32 +: 32] = rng;
        end
    endtask

    task automatic defaults();
        form_sel = 2'b10; len_sel = 2'b10; mask_en = 1'b0; lane_mask = '0;
        zero_mode = 1'b0; src_mem = 1'b0; bcst_rnd = 1'b0;
        emb_rc = 2'b00; glob_rc = 2'b00; spec_field = 4'hF;
    endtask

    initial begin
        #(CLK_P * 150000);
        failures++;
        $display("FAIL R11 watchdog act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12 reset result", res_vec, '0);
        chk("R12 reset flags", VW'({out_valid, inexact, bad_enc}), VW'(0));
        rst_n = 1'b1;
        @(negedge clk);

        // R2 literal corners to nearest
        defaults();
        fill_random();
        src_vec[31:0] = 32'h0; src_vec[63:32] = 32'h8000_0000;
        src_vec[95:64] = 32'h7FFF_FFFF; src_vec[127:96] = 32'hFFFF_FFFF;
        issue("R2 corners");
        chk("R2 zero", VW'(res_vec[31:0]), VW'(32'h0000_0000));
        chk("R2 min int", VW'(res_vec[63:32]), VW'(32'hCF00_0000));
        chk("R2 carry", VW'(res_vec[95:64]), VW'(32'h4F00_0000));
        chk("R2 minus one", VW'(res_vec[127:96]), VW'(32'hBF80_0000));
        // R3 toward zero literal
        glob_rc = 2'b11;
        issue("R3 tozero");
        chk("R3 tozero max", VW'(res_vec[95:64]), VW'(32'h4EFF_FFFF));

        // R2 R3 sweep over rounding codes
        for (int rm = 0; rm < 4; rm++) begin
            for (int r = 0; r < 40; r++) begin
                defaults();
                glob_rc = 2'(rm);
                fill_random();
                if (r == 0)
                    for (int j = 0; j < NL; j++) src_vec[j*32 +: 32] = corner(j);
                issue("R2 R3 sweep");
            end
        end

        // R4 R5 R9 mask sweep at 4 lanes
        for (int z = 0; z < 2; z++) begin
            for (int mk = 0; mk < 16; mk++) begin
                defaults();
                fill_random();
                for (int j = 0; j < 4; j++) src_vec[j*32 +: 32] = corner(7 + j);
                len_sel = 2'b00; mask_en = 1'b1; zero_mode = z[0];
                rng = next_rng(rng);
                lane_mask = {rng[NL-1:4], 4'(mk)};
                issue("R4 R5 mask");
            end
        end
        // R4 masking off ignores the mask
        defaults(); fill_random(); lane_mask = '0; mask_en = 1'b0;
        issue("R4 mask disabled");
        defaults(); fill_random(); form_sel = 2'b01; mask_en = 1'b1; lane_mask = '0;
        issue("R4 plain form ignores mask");

        // R1 R8 forms by lengths
        for (int f = 0; f < 3; f++) begin
            for (int l = 0; l < 4; l++) begin
                defaults(); fill_random();
                form_sel = 2'(f); len_sel = 2'(l);
                issue("R1 R8 length");
            end
        end

        // R6 broadcast
        defaults(); fill_random(); len_sel = 2'b01; src_mem = 1'b1; bcst_rnd = 1'b1;
        src_vec[31:0] = 32'h0123_4567;
        issue("R6 broadcast");
        chk("R6 lane7 copy", VW'(res_vec[255:224]), VW'(res_vec[31:0]));
        src_mem = 1'b0;
        issue("R6 register no broadcast");

        // R7 rounding source
        for (int c = 0; c < 4; c++) begin
            defaults(); fill_random();
            for (int j = 0; j < NL; j++) src_vec[j*32 +: 32] = corner(j);
            emb_rc = 2'b11; glob_rc = 2'b10; bcst_rnd = 1'b1;
            len_sel = (c == 1) ? 2'b01 : 2'b10;
            src_mem = (c == 2);
            form_sel = (c == 3) ? 2'b01 : 2'b10;
            issue("R7 rounding source");
        end
        defaults(); fill_random(); src_vec[31:0] = 32'h7FFF_FFFF;
        bcst_rnd = 1'b1; emb_rc = 2'b11; glob_rc = 2'b00;
        issue("R7 embedded");
        chk("R7 embedded tozero", VW'(res_vec[31:0]), VW'(32'h4EFF_FFFF));

        // R10 invalid encodings
        defaults(); fill_random(); form_sel = 2'b01; spec_field = 4'h7;
        issue("R10 plain bad");
        form_sel = 2'b10; spec_field = 4'h0;
        issue("R10 masked bad");
        form_sel = 2'b00;
        issue("R10 legacy never faults");

        // R11 hold without strobe
        defaults(); fill_random();
        issue("R11 pre-hold");
        begin
            logic [VW-1:0] held;
            logic hix;
            held = res_vec;
            hix = inexact;
            fill_random();
            @(negedge clk);
            chk("R11 idle valid", VW'(out_valid), VW'(0));
            chk("R11 held result", res_vec, held);
            chk("R11 held inexact", VW'(inexact), VW'(hix));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule